// File: doc/BRIEF.md
# Column-Ordered Multi-Chain Scan Loader with Per-Chain Polarity Split

This block takes a stream of decoded words, each as wide as the number of parallel scan chains, and shifts them into equal-length chains. Bit i of every accepted word goes to chain i. A word therefore fills one column of scan cells across all chains, and successive words fill successive columns until a full vector of `CHAIN_LEN` columns has been loaded.

Each chain has a split point given on its own configuration input. Columns before the split carry stored data as it is. Columns at or past the split carry the complement. This lets a stored vector that is mostly zeros place a mostly-ones region at the tail of each chain, and the split may sit at a different column in each chain. A second per-chain input gives the chain's real length. Columns beyond that length are padding: the chain does not shift for them and its data line is held at 0.

The chains move in lockstep under one shared shift strobe, with a per-chain enable that masks out the padded columns. When the last column of a vector has been shifted, a done pulse is raised and the column position returns to zero.

Top module: `scan_col_distributor`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `shift_en`, `chain_en`, `scan_out` and `vec_done` are all 0. `in_ready` is 0 while `rst` is high.
- R2: `in_ready` is 1 from the first clock edge after `rst` is released, and stays 1. A word is accepted on every edge where `in_valid` and `in_ready` are both 1.
- R3: For an accepted word at column c, on the cycle after acceptance `scan_out[i]` equals `in_word[i]` when c < `chain_bnd[i]` and c < `chain_len[i]`.
- R4: When c >= `chain_bnd[i]` and c < `chain_len[i]`, `scan_out[i]` equals the complement of `in_word[i]`. A split of 0 inverts every column of the chain. A split >= `CHAIN_LEN` inverts none.
- R5: Each chain uses only its own split field. Field i of `chain_bnd` and field i of `chain_len` occupy bits [i*BW +: BW], where BW = clog2(`CHAIN_LEN`+1).
- R6: When c >= `chain_len[i]`, `chain_en[i]` is 0 and `scan_out[i]` is 0 on the cycle after acceptance. Otherwise `chain_en[i]` is 1.
- R7: `shift_en` is 1 exactly on the cycle after a word is accepted. No bit of `chain_en` is 1 unless `shift_en` is 1.
- R8: Without an accepted word, `shift_en`, `chain_en` and `scan_out` are 0 and the column does not advance.
- R9: Columns advance 0, 1, …, `CHAIN_LEN`-1 over accepted words. `vec_done` is 1 together with the shift of column `CHAIN_LEN`-1, and the next accepted word is column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | NCHAIN | Decoded word, bit i for chain i |
| in_valid | input | 1 | Word present |
| in_ready | output | 1 | Block can accept a word |
| chain_bnd | input | NCHAIN*BW | Per-chain first inverted column |
| chain_len | input | NCHAIN*BW | Per-chain real length in cells |
| scan_out | output | NCHAIN | Registered scan data per chain |
| chain_en | output | NCHAIN | Registered per-chain shift enable |
| shift_en | output | 1 | Registered shared shift strobe |
| vec_done | output | 1 | Registered pulse on the last column's shift |

## Verification
Every result appears one cycle after its cause. `scan_out`, `chain_en`, `shift_en` and `vec_done` change on the edge that accepts a word, and `in_ready` rises on the first edge after reset is released. The bench drives inputs on falling edges and samples on the next falling edge, which is half a cycle after the edge that registered the result. Idle gaps between words are sampled in the same way, to confirm that nothing shifts and that the column position survives the stall.

// File: rtl/scd_pkg.sv
package scd_pkg;
  // index width for a count range of n values, never below one bit
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/scd_col_counter.sv
module scd_col_counter #(
  parameter int CHAIN_LEN = 8,
  parameter int CW        = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [CW-1:0] col,
  output logic          last
);
  localparam logic [CW-1:0] LAST_COL = CW'(CHAIN_LEN - 1);

  assign last = (col == LAST_COL);

  always_ff @(posedge clk) begin
    if (rst)       col <= '0;
    else if (step) col <= last ? '0 : col + 1'b1;
  end
endmodule

// File: rtl/scd_lane.sv
module scd_lane #(
  parameter int CW = 3,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          bit_in,
  input  logic [CW-1:0] col,
  input  logic [BW-1:0] bnd,
  input  logic [BW-1:0] len,
  output logic          data_q,
  output logic          en_q
);
  logic [BW-1:0] col_x;
  logic          live;
  logic          flip;

  assign col_x = BW'(col);
  assign live  = (col_x < len);
  assign flip  = (col_x >= bnd);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (fire) begin
      data_q <= live & (bit_in ^ flip);
      en_q   <= live;
    end else begin
      data_q <= 1'b0;
      en_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_col_distributor.sv
module scan_col_distributor #(
  parameter int NCHAIN    = 4,
  parameter int CHAIN_LEN = 8,
  localparam int BW       = scd_pkg::idx_bits(CHAIN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCHAIN-1:0]    in_word,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NCHAIN*BW-1:0] chain_bnd,
  input  logic [NCHAIN*BW-1:0] chain_len,
  output logic [NCHAIN-1:0]    scan_out,
  output logic [NCHAIN-1:0]    chain_en,
  output logic                 shift_en,
  output logic                 vec_done
);
  localparam int CW = scd_pkg::idx_bits(CHAIN_LEN);

  logic          fire;
  logic [CW-1:0] col;
  logic          last;

  assign fire = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready <= 1'b0;
      shift_en <= 1'b0;
      vec_done <= 1'b0;
    end else begin
      in_ready <= 1'b1;
      shift_en <= fire;
      vec_done <= fire & last;
    end
  end

  scd_col_counter #(.CHAIN_LEN(CHAIN_LEN), .CW(CW)) cnt_i (
    .clk (clk),
    .rst (rst),
    .step(fire),
    .col (col),
    .last(last)
  );

  for (genvar g = 0; g < NCHAIN; g++) begin : g_lane
    scd_lane #(.CW(CW), .BW(BW)) lane_i (
      .clk   (clk),
      .rst   (rst),
      .fire  (fire),
      .bit_in(in_word[g]),
      .col   (col),
      .bnd   (chain_bnd[g*BW +: BW]),
      .len   (chain_len[g*BW +: BW]),
      .data_q(scan_out[g]),
      .en_q  (chain_en[g])
    );
  end
endmodule

// File: rtl/scan_col_distributor_chk.sv
module scan_col_distributor_chk #(
  parameter int NCHAIN    = 4,
  parameter int CHAIN_LEN = 8,
  localparam int BW       = scd_pkg::idx_bits(CHAIN_LEN + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NCHAIN-1:0]    in_word,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [NCHAIN*BW-1:0] chain_bnd,
  input logic [NCHAIN*BW-1:0] chain_len,
  input logic [NCHAIN-1:0]    scan_out,
  input logic [NCHAIN-1:0]    chain_en,
  input logic                 shift_en,
  input logic                 vec_done
);
  localparam int SW = scd_pkg::idx_bits(CHAIN_LEN);

  // shadow column count, advanced by observed shifts only
  logic [SW-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (shift_en) seen <= (seen == SW'(CHAIN_LEN - 1)) ? '0 : seen + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!shift_en && chain_en == '0 && scan_out == '0 && !vec_done));

  // R7
  shift_cause_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> $past(in_valid && in_ready));

  // R7
  enable_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (chain_en != '0) |-> shift_en);

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_out & ~chain_en) == '0);

  // R9
  done_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> (vec_done == (seen == SW'(CHAIN_LEN - 1))));

  // R9
  done_needs_shift_chk: assert property (@(posedge clk) disable iff (rst)
    vec_done |-> shift_en);

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);
endmodule

bind scan_col_distributor scan_col_distributor_chk #(
  .NCHAIN(NCHAIN), .CHAIN_LEN(CHAIN_LEN)
) chk_i (
  .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
  .in_ready(in_ready), .chain_bnd(chain_bnd), .chain_len(chain_len),
  .scan_out(scan_out), .chain_en(chain_en), .shift_en(shift_en),
  .vec_done(vec_done)
);

// File: tb/scan_col_distributor_tb_top.sv
`timescale 1ns/1ps
module scan_col_distributor_tb_top;
  localparam int M  = 4;
  localparam int L  = 8;
  localparam int BW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [M-1:0]    in_word = '0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [M*BW-1:0] chain_bnd = '0;
  logic [M*BW-1:0] chain_len = '0;
  logic [M-1:0]    scan_out;
  logic [M-1:0]    chain_en;
  logic            shift_en;
  logic            vec_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int col_exp = 0;
  int bnd_v [M];
  int len_v [M];

  always #4 clk = ~clk;

  scan_col_distributor #(.NCHAIN(M), .CHAIN_LEN(L)) dut_i (
    .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .chain_bnd(chain_bnd), .chain_len(chain_len),
    .scan_out(scan_out), .chain_en(chain_en), .shift_en(shift_en),
    .vec_done(vec_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int cfg);
    for (int i = 0; i < M; i++) begin
      bnd_v[i] = (cfg + 3 * i) % (L + 2);
      len_v[i] = L - ((cfg + i) % 3);
      chain_bnd[i*BW +: BW] = BW'(bnd_v[i]);
      chain_len[i*BW +: BW] = BW'(len_v[i]);
    end
  endtask

  // called at a falling edge; leaves valid high, returns at the next falling edge after checking
  task automatic push(input logic [M-1:0] w);
    logic [M-1:0] eo, ee;
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk);
    for (int i = 0; i < M; i++) begin
      ee[i] = (col_exp < len_v[i]);
      eo[i] = ee[i] & (w[i] ^ (col_exp >= bnd_v[i]));
    end
    chk(shift_en === 1'b1, "R7 shift_en", int'(shift_en), 1);
    // R3 R4 R5 per-chain data, R6 pad masking
    chk(scan_out === eo, "R3/R4/R5 scan_out", int'(scan_out), int'(eo));
    chk(chain_en === ee, "R6 chain_en", int'(chain_en), int'(ee));
    chk(vec_done === (col_exp == L - 1), "R9 vec_done", int'(vec_done), int'(col_exp == L - 1));
    col_exp = (col_exp == L - 1) ? 0 : col_exp + 1;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_word  = '1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      // R8 no shift without an accepted word
      chk(shift_en === 1'b0 && chain_en === '0 && scan_out === '0 && vec_done === 1'b0,
          "R8 idle", int'({shift_en, chain_en, scan_out}), 0);
    end
  endtask

  initial begin
    set_cfg(0);
    in_valid = 1'b1;
    in_word  = '1;
    repeat (3) @(negedge clk);
    // R1 outputs quiet under reset, even with a word offered
    chk(in_ready === 1'b0, "R1 in_ready", int'(in_ready), 0);
    chk(shift_en === 1'b0 && chain_en === '0 && scan_out === '0 && vec_done === 1'b0,
        "R1 outputs", int'({shift_en, chain_en, scan_out}), 0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1, "R2 in_ready", int'(in_ready), 1);
    chk(shift_en === 1'b0 && scan_out === '0, "R1 after release", int'(shift_en), 0);

    for (int cfg = 0; cfg < 20; cfg++) begin
      set_cfg(cfg);
      for (int v = 0; v < 2; v++) begin
        for (int c = 0; c < L; c++) begin
          push(M'((v * 5 + c * 3 + cfg * 7) ^ (c >> 1)));
          chk(in_ready === 1'b1, "R2 ready held", int'(in_ready), 1);
          // stall in some columns; column must not move (R8, R9)
          if (((c + cfg + v) % 3) == 0) idle(1 + (c % 2));
        end
      end
      idle(1);
    end

    // exhaustive word sweep on one configuration, back-to-back (R3 R4)
    set_cfg(5);
    for (int w = 0; w < (1 << M); w++) push(M'(w));
    idle(2);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule